// File: doc/BRIEF.md
# Device Error Event Classifier

This block takes error events detected inside a device function, one per handshake, and turns each into updates of the function's error state and, when the reporting controls allow, a single error message toward the upstream port. An event carries a 32-bit status word with the error bit, a flag that marks it correctable, a flag that allows an uncorrectable non-fatal error to be treated as advisory, and a 16-bit requester source ID. The block screens the event, sorts it into correctable, non-fatal or fatal, and applies the mask and severity settings it is given. It sets the sticky device-level detected bits and the per-error status bits. It requests a header log entry when the error must be logged. It then decides whether to send a message and which severity the message carries.

The header log storage sits outside the block and reports through `log_full` that it cannot take another entry. When a logging request meets a full log, the block takes one more cycle to raise a follow-on correctable header-log-overflow error. That error goes through the same rules as any other correctable error, and no new request is taken while it is processed. Configuration decoding and clearing of the status bits are handled elsewhere, so the status outputs here only ever accumulate.

Top module: `aer_err_classifier`

## Requirements
- R1: The status word is first ANDed with the supported set: correctable bits 0, 6, 7, 8, 12, 13, 14 and 15 (mask 0x0000F1C1), or uncorrectable bits 0, 4, 5 and 12 to 25 (mask 0x03FFF031). If other than exactly one bit remains, the event changes no state and sends no message.
- R2: A valid correctable event sets its bit in `cor_status` and sets device status bit 0 (correctable detected).
- R3: An uncorrectable event is fatal when its bit is also set in `unc_sev`, otherwise non-fatal. It sets device status bit 2 (fatal) or bit 1 (non-fatal), and sets bit 3 (unsupported request) when it is uncorrectable bit 20.
- R4: A correctable event whose bit is set in `cor_mask` sets its status bit and sends no message. An uncorrectable event whose bit is set in `unc_mask` sets its status bit, is not logged and sends no message.
- R5: A non-fatal uncorrectable event with the advisory flag is handled as correctable error bit 13. It sets `cor_status` bit 13 and device status bit 0, plus bit 3 for an unsupported request. If `cor_mask` bit 13 is clear, it is logged and its `unc_status` bit is set, but only when its bit is clear in `unc_mask`. A fatal event ignores the advisory flag.
- R6: A correctable message (advisory ones included) needs `ctl_cor_en`. One caused by an unsupported request also needs `ctl_ur_en`.
- R7: A fatal message needs `ctl_serr_en` or `ctl_fat_en`, and a non-fatal message needs `ctl_serr_en` or `ctl_nf_en`. An unsupported request with both `ctl_ur_en` and `ctl_serr_en` low sends nothing.
- R8: When an event must be logged while `log_full` is high, there is no log push. In the next cycle the block holds `req_ready` low and processes correctable error bit 15 with the same source ID. That message follows the first one.
- R9: Status updates, `log_push` and `msg_valid` appear in the cycle after acceptance. `msg_valid` is a one-cycle pulse with `msg_sev` (0 correctable, 1 non-fatal, 2 fatal) and the event's `msg_src`.
- R10: A logged event pulses `log_push` with `log_idx` equal to the index of its status bit.
- R11: After reset all status outputs are zero, no message or push is pending, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Error event offered |
| req_ready | output | 1 | Event can be taken this cycle |
| req_status | input | 32 | Error status word |
| req_corr | input | 1 | Event is correctable |
| req_adv | input | 1 | Non-fatal event may be advisory |
| req_src | input | 16 | Requester source ID |
| cor_mask | input | 32 | Correctable error mask |
| unc_mask | input | 32 | Uncorrectable error mask |
| unc_sev | input | 32 | Uncorrectable severity, 1 = fatal |
| ctl_cor_en | input | 1 | Correctable reporting enable |
| ctl_nf_en | input | 1 | Non-fatal reporting enable |
| ctl_fat_en | input | 1 | Fatal reporting enable |
| ctl_ur_en | input | 1 | Unsupported-request reporting enable |
| ctl_serr_en | input | 1 | System error enable from the command register |
| log_full | input | 1 | Header log cannot accept an entry |
| dev_status | output | 4 | Sticky detected bits: 0 corr, 1 non-fatal, 2 fatal, 3 unsupported request |
| cor_status | output | 32 | Sticky correctable status |
| unc_status | output | 32 | Sticky uncorrectable status |
| log_push | output | 1 | Header log write pulse |
| log_idx | output | 5 | Bit index of the logged error |
| msg_valid | output | 1 | Error message pulse |
| msg_sev | output | 2 | Message severity |
| msg_src | output | 16 | Message source ID |

## Verification
The hardest case to reach is the overflow follow-on. It needs an error that is both loggable and unmasked, presented while the external log reports full. The bench must then see two messages in consecutive cycles, with `req_ready` low between them. The stimulus raises `log_full` together with the request and checks the ready gap and the message order through the scoreboard. The advisory path is also hard to reach, because it depends on three masks at once. The bench sets `unc_mask` and `cor_mask` one at a time, so each branch shows its own pattern on the status outputs.

// File: rtl/aer_cls_pkg.sv
`timescale 1ns/1ps
package aer_cls_pkg;

    localparam int STAT_W = 32;
    localparam int IDX_W  = $clog2(STAT_W);
    localparam int DEV_W  = 4;

    // Bit positions that software decodes; they must stay where they are.
    localparam int UNC_UR_BIT  = 20;
    localparam int COR_ADV_BIT = 13;
    localparam int COR_HLO_BIT = 15;

    localparam int DEV_COR = 0;
    localparam int DEV_NF  = 1;
    localparam int DEV_FAT = 2;
    localparam int DEV_UR  = 3;

    localparam logic [STAT_W-1:0] COR_SUPPORTED = 32'h0000_F1C1;
    localparam logic [STAT_W-1:0] UNC_SUPPORTED = 32'h03FF_F031;

    typedef enum logic [1:0] {
        SEV_COR      = 2'd0,
        SEV_NONFATAL = 2'd1,
        SEV_FATAL    = 2'd2
    } sev_e;

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic              corr;
        logic              adv;
    } evt_t;

    typedef struct packed {
        logic              ok;
        logic [STAT_W-1:0] bitv;
        logic [IDX_W-1:0]  idx;
        logic              fatal;
        logic              ur;
    } cls_t;

    typedef struct packed {
        logic [DEV_W-1:0]  dev_set;
        logic [STAT_W-1:0] cor_set;
        logic [STAT_W-1:0] unc_set;
        logic              log_req;
        logic              msg_en;
        sev_e              sev;
    } act_t;

    function automatic logic is_single(input logic [STAT_W-1:0] v);
        return (v != '0) && ((v & (v - 1'b1)) == '0);
    endfunction

    function automatic logic [IDX_W-1:0] bit_index(input logic [STAT_W-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < STAT_W; i++) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/aer_evt_decode.sv
`timescale 1ns/1ps
module aer_evt_decode
    import aer_cls_pkg::*;
(
    input  evt_t              evt,
    input  logic [STAT_W-1:0] unc_sev,
    output cls_t              cls
);

    logic [STAT_W-1:0] kept;

    always_comb begin
        kept      = evt.status & (evt.corr ? COR_SUPPORTED : UNC_SUPPORTED);
        cls.ok    = is_single(kept);
        cls.bitv  = kept;
        cls.idx   = bit_index(kept);
        cls.fatal = !evt.corr && ((kept & unc_sev) != '0);
        cls.ur    = !evt.corr && kept[UNC_UR_BIT];
    end

endmodule

// File: rtl/aer_evt_route.sv
`timescale 1ns/1ps
module aer_evt_route
    import aer_cls_pkg::*;
(
    input  logic              ok,
    input  logic              corr,
    input  logic              adv,
    input  logic [STAT_W-1:0] bitv,
    input  logic              fatal,
    input  logic              ur,
    input  logic [STAT_W-1:0] cor_mask,
    input  logic [STAT_W-1:0] unc_mask,
    input  logic              ctl_cor_en,
    input  logic              ctl_nf_en,
    input  logic              ctl_fat_en,
    input  logic              ctl_ur_en,
    input  logic              ctl_serr_en,
    output act_t              act
);

    logic unc_masked;
    logic cor_masked;

    always_comb begin
        unc_masked = (bitv & unc_mask) != '0;
        cor_masked = (bitv & cor_mask) != '0;
        act        = '0;
        act.sev    = SEV_COR;
        if (ok) begin
            if (corr) begin
                act.dev_set[DEV_COR] = 1'b1;
                act.cor_set          = bitv;
                act.msg_en           = !cor_masked && ctl_cor_en;
            end else if (!fatal && adv) begin
                act.dev_set[DEV_COR]     = 1'b1;
                act.dev_set[DEV_UR]      = ur;
                act.cor_set[COR_ADV_BIT] = 1'b1;
                if (!cor_mask[COR_ADV_BIT]) begin
                    if (!unc_masked) begin
                        act.log_req = 1'b1;
                        act.unc_set = bitv;
                    end
                    act.msg_en = ctl_cor_en && (!ur || ctl_ur_en);
                end
            end else begin
                act.dev_set[DEV_FAT] = fatal;
                act.dev_set[DEV_NF]  = !fatal;
                act.dev_set[DEV_UR]  = ur;
                act.unc_set          = bitv;
                if (!unc_masked) begin
                    act.log_req = 1'b1;
                    act.sev     = fatal ? SEV_FATAL : SEV_NONFATAL;
                    if (ur && !ctl_ur_en && !ctl_serr_en)
                        act.msg_en = 1'b0;
                    else if (fatal)
                        act.msg_en = ctl_serr_en || ctl_fat_en;
                    else
                        act.msg_en = ctl_serr_en || ctl_nf_en;
                end
            end
        end
    end

endmodule

// File: rtl/aer_err_classifier.sv
`timescale 1ns/1ps
module aer_err_classifier
    import aer_cls_pkg::*;
#(
    parameter int SRC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [STAT_W-1:0] req_status,
    input  logic              req_corr,
    input  logic              req_adv,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [STAT_W-1:0] cor_mask,
    input  logic [STAT_W-1:0] unc_mask,
    input  logic [STAT_W-1:0] unc_sev,
    input  logic              ctl_cor_en,
    input  logic              ctl_nf_en,
    input  logic              ctl_fat_en,
    input  logic              ctl_ur_en,
    input  logic              ctl_serr_en,
    input  logic              log_full,
    output logic [DEV_W-1:0]  dev_status,
    output logic [STAT_W-1:0] cor_status,
    output logic [STAT_W-1:0] unc_status,
    output logic              log_push,
    output logic [IDX_W-1:0]  log_idx,
    output logic              msg_valid,
    output logic [1:0]        msg_sev,
    output logic [SRC_W-1:0]  msg_src
);

    logic             pend;
    logic [SRC_W-1:0] pend_src;
    logic             fire;
    evt_t             evt_sel;
    logic [SRC_W-1:0] src_sel;
    cls_t             cls;
    act_t             act;

    assign req_ready = !pend;
    assign fire      = pend || req_valid;

    // The overflow follow-on takes priority over a new request.
    always_comb begin
        if (pend) begin
            evt_sel.status = STAT_W'(1) << COR_HLO_BIT;
            evt_sel.corr   = 1'b1;
            evt_sel.adv    = 1'b0;
            src_sel        = pend_src;
        end else begin
            evt_sel.status = req_status;
            evt_sel.corr   = req_corr;
            evt_sel.adv    = req_adv;
            src_sel        = req_src;
        end
    end

    aer_evt_decode u_decode (
        .evt     (evt_sel),
        .unc_sev (unc_sev),
        .cls     (cls)
    );

    aer_evt_route u_route (
        .ok          (cls.ok),
        .corr        (evt_sel.corr),
        .adv         (evt_sel.adv),
        .bitv        (cls.bitv),
        .fatal       (cls.fatal),
        .ur          (cls.ur),
        .cor_mask    (cor_mask),
        .unc_mask    (unc_mask),
        .ctl_cor_en  (ctl_cor_en),
        .ctl_nf_en   (ctl_nf_en),
        .ctl_fat_en  (ctl_fat_en),
        .ctl_ur_en   (ctl_ur_en),
        .ctl_serr_en (ctl_serr_en),
        .act         (act)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend       <= 1'b0;
            pend_src   <= '0;
            dev_status <= '0;
            cor_status <= '0;
            unc_status <= '0;
            log_push   <= 1'b0;
            log_idx    <= '0;
            msg_valid  <= 1'b0;
            msg_sev    <= 2'd0;
            msg_src    <= '0;
        end else begin
            msg_valid <= fire && act.msg_en;
            log_push  <= fire && act.log_req && !log_full;
            pend      <= fire && act.log_req && log_full;
            if (fire) begin
                dev_status <= dev_status | act.dev_set;
                cor_status <= cor_status | act.cor_set;
                unc_status <= unc_status | act.unc_set;
                log_idx    <= cls.idx;
                msg_sev    <= act.sev;
                msg_src    <= src_sel;
                pend_src   <= src_sel;
            end
        end
    end

endmodule

// File: rtl/aer_err_classifier_chk.sv
`timescale 1ns/1ps
module aer_err_classifier_chk
    import aer_cls_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fire,
    input logic              pend,
    input logic              req_ready,
    input logic              ctl_cor_en,
    input logic              ctl_fat_en,
    input logic              ctl_serr_en,
    input logic [DEV_W-1:0]  dev_status,
    input logic [STAT_W-1:0] cor_status,
    input logic [STAT_W-1:0] unc_status,
    input logic              log_push,
    input logic [IDX_W-1:0]  log_idx,
    input logic              msg_valid,
    input logic [1:0]        msg_sev
);

    // R9
    msg_after_fire_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> $past(fire));

    // R8
    busy_during_followon_chk: assert property (@(posedge clk) disable iff (rst)
        pend |-> !req_ready);

    // R2
    cor_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (cor_status & $past(cor_status)) == $past(cor_status));

    // R3
    dev_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_status & $past(dev_status)) == $past(dev_status));

    // R1
    unc_supported_chk: assert property (@(posedge clk) disable iff (rst)
        (unc_status & ~UNC_SUPPORTED) == '0);

    // R7
    fatal_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_sev == SEV_FATAL) |-> $past(ctl_serr_en || ctl_fat_en));

    // R6
    cor_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_sev == SEV_COR) |-> $past(ctl_cor_en));

    // R10
    log_bit_set_chk: assert property (@(posedge clk) disable iff (rst)
        log_push |-> unc_status[log_idx]);

endmodule

bind aer_err_classifier aer_err_classifier_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .fire        (fire),
    .pend        (pend),
    .req_ready   (req_ready),
    .ctl_cor_en  (ctl_cor_en),
    .ctl_fat_en  (ctl_fat_en),
    .ctl_serr_en (ctl_serr_en),
    .dev_status  (dev_status),
    .cor_status  (cor_status),
    .unc_status  (unc_status),
    .log_push    (log_push),
    .log_idx     (log_idx),
    .msg_valid   (msg_valid),
    .msg_sev     (msg_sev)
);

// File: tb/aer_err_classifier_tb.sv
`timescale 1ns/1ps
module aer_err_classifier_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_status = '0;
    logic        req_corr = 1'b0;
    logic        req_adv = 1'b0;
    logic [15:0] req_src = '0;
    logic [31:0] cor_mask = '0;
    logic [31:0] unc_mask = '0;
    logic [31:0] unc_sev = '0;
    logic        ctl_cor_en = 1'b1;
    logic        ctl_nf_en = 1'b1;
    logic        ctl_fat_en = 1'b1;
    logic        ctl_ur_en = 1'b1;
    logic        ctl_serr_en = 1'b0;
    logic        log_full = 1'b0;
    logic [3:0]  dev_status;
    logic [31:0] cor_status;
    logic [31:0] unc_status;
    logic        log_push;
    logic [4:0]  log_idx;
    logic        msg_valid;
    logic [1:0]  msg_sev;
    logic [15:0] msg_src;

    localparam logic [1:0] S_COR = 2'd0, S_NF = 2'd1, S_FAT = 2'd2;

    always #2.5 clk = ~clk;

    aer_err_classifier u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_status(req_status), .req_corr(req_corr), .req_adv(req_adv),
        .req_src(req_src), .cor_mask(cor_mask), .unc_mask(unc_mask),
        .unc_sev(unc_sev), .ctl_cor_en(ctl_cor_en), .ctl_nf_en(ctl_nf_en),
        .ctl_fat_en(ctl_fat_en), .ctl_ur_en(ctl_ur_en), .ctl_serr_en(ctl_serr_en),
        .log_full(log_full), .dev_status(dev_status), .cor_status(cor_status),
        .unc_status(unc_status), .log_push(log_push), .log_idx(log_idx),
        .msg_valid(msg_valid), .msg_sev(msg_sev), .msg_src(msg_src)
    );

    typedef struct {
        logic [1:0]  sev;
        logic [15:0] src;
        string       tag;
    } exp_msg_t;

    exp_msg_t    sb[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    logic [31:0] exp_cor = '0;
    logic [31:0] exp_unc = '0;
    logic [3:0]  exp_dev = '0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Monitor: every message pulse is matched against the scoreboard front.
    always @(negedge clk) begin
        if (!rst && msg_valid) begin
            if (sb.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R9 unexpected message actual=sev%0d expected=none", msg_sev);
            end else begin
                exp_msg_t e;
                e = sb.pop_front();
                chk({e.tag, " msg sev"}, 64'(msg_sev), 64'(e.sev));
                chk({e.tag, " msg src"}, 64'(msg_src), 64'(e.src));
            end
        end
    end

    // Driver: called at a negedge; pushes expected messages, then drives one event.
    task automatic send(input logic [31:0] st, input logic corr, input logic adv,
                        input logic [15:0] src, input logic full,
                        input bit m, input logic [1:0] sev,
                        input bit lg, input logic [4:0] li,
                        input bit ovf, input string tag);
        if (m)   sb.push_back('{sev, src, tag});
        if (ovf) sb.push_back('{S_COR, src, "R8"});
        req_status = st; req_corr = corr; req_adv = adv; req_src = src;
        log_full = full; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; log_full = 1'b0;
        chk({tag, " log_push"}, 64'(log_push), 64'(lg));
        if (lg) chk({tag, " R10 log_idx"}, 64'(log_idx), 64'(li));
        chk({tag, " ready"}, 64'(req_ready), 64'(!ovf));
        if (ovf) begin
            @(negedge clk);
            chk("R8 no push on follow-on", 64'(log_push), 64'(0));
            chk("R8 ready back", 64'(req_ready), 64'(1));
        end
        chk({tag, " cor_status"}, 64'(cor_status), 64'(exp_cor));
        chk({tag, " unc_status"}, 64'(unc_status), 64'(exp_unc));
        chk({tag, " dev_status"}, 64'(dev_status), 64'(exp_dev));
        @(negedge clk);
        chk({tag, " R9 all messages seen"}, 64'(sb.size()), 64'(0));
        sb.delete();
    endtask

    initial begin
        #500000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 dev", 64'(dev_status), 64'(0));
        chk("R11 cor", 64'(cor_status), 64'(0));
        chk("R11 unc", 64'(unc_status), 64'(0));
        chk("R11 msg", 64'(msg_valid), 64'(0));
        chk("R11 push", 64'(log_push), 64'(0));
        chk("R11 ready", 64'(req_ready), 64'(1));

        // R2 correctable bad-TLP
        exp_cor |= 32'h40; exp_dev[0] = 1'b1;
        send(32'h40, 1, 0, 16'h0100, 0, 1, S_COR, 0, 0, 0, "R2");

        // R1 rejects: unsupported only, two bits, two uncorrectable bits
        send(32'h2, 1, 0, 16'h0101, 0, 0, S_COR, 0, 0, 0, "R1");
        send(32'h41, 1, 0, 16'h0102, 0, 0, S_COR, 0, 0, 0, "R1");
        send(32'h3000, 0, 0, 16'h0103, 0, 0, S_COR, 0, 0, 0, "R1");
        // R1 unsupported bit stripped leaves a single valid bit
        exp_cor |= 32'h1;
        send(32'h3, 1, 0, 16'h0104, 0, 1, S_COR, 0, 0, 0, "R1");

        // R3 fatal by severity
        unc_sev = 32'h1 << 18;
        exp_unc |= 32'h1 << 18; exp_dev[2] = 1'b1;
        send(32'h1 << 18, 0, 0, 16'h0208, 0, 1, S_FAT, 1, 18, 0, "R3");
        // R3 non-fatal
        exp_unc |= 32'h1 << 12; exp_dev[1] = 1'b1;
        send(32'h1 << 12, 0, 0, 16'h0209, 0, 1, S_NF, 1, 12, 0, "R3");
        // R3 unsupported request
        exp_unc |= 32'h1 << 20; exp_dev[3] = 1'b1;
        send(32'h1 << 20, 0, 0, 16'h020A, 0, 1, S_NF, 1, 20, 0, "R3");

        // R7 UR gating
        ctl_ur_en = 1'b0;
        send(32'h1 << 20, 0, 0, 16'h0300, 0, 0, S_NF, 1, 20, 0, "R7");
        ctl_serr_en = 1'b1; ctl_nf_en = 1'b0;
        send(32'h1 << 20, 0, 0, 16'h0301, 0, 1, S_NF, 1, 20, 0, "R7");
        ctl_serr_en = 1'b0;
        ctl_fat_en = 1'b0;
        send(32'h1 << 18, 0, 0, 16'h0302, 0, 0, S_FAT, 1, 18, 0, "R7");
        exp_unc |= 32'h1 << 13;
        send(32'h1 << 13, 0, 0, 16'h0303, 0, 0, S_NF, 1, 13, 0, "R7");
        ctl_fat_en = 1'b1;
        send(32'h1 << 18, 0, 0, 16'h0304, 0, 1, S_FAT, 1, 18, 0, "R7");
        ctl_nf_en = 1'b1;

        // R4 masked events
        cor_mask = 32'h1 << 7;
        exp_cor |= 32'h1 << 7;
        send(32'h1 << 7, 1, 0, 16'h0400, 0, 0, S_COR, 0, 0, 0, "R4");
        unc_mask = 32'h1 << 14;
        exp_unc |= 32'h1 << 14;
        send(32'h1 << 14, 0, 0, 16'h0401, 0, 0, S_NF, 0, 0, 0, "R4");

        // R6 correctable reporting gate
        ctl_cor_en = 1'b0;
        exp_cor |= 32'h1 << 8;
        send(32'h1 << 8, 1, 0, 16'h0500, 0, 0, S_COR, 0, 0, 0, "R6");
        ctl_cor_en = 1'b1; ctl_ur_en = 1'b0;
        exp_cor |= 32'h1 << 13;
        send(32'h1 << 20, 0, 1, 16'h0501, 0, 0, S_COR, 1, 20, 0, "R6");
        ctl_ur_en = 1'b1;

        // R5 advisory non-fatal
        exp_unc |= 32'h1 << 16;
        send(32'h1 << 16, 0, 1, 16'h0600, 0, 1, S_COR, 1, 16, 0, "R5");
        unc_mask = unc_mask | (32'h1 << 17);
        send(32'h1 << 17, 0, 1, 16'h0601, 0, 1, S_COR, 0, 0, 0, "R5");
        unc_sev = unc_sev | (32'h1 << 19);
        exp_unc |= 32'h1 << 19;
        send(32'h1 << 19, 0, 1, 16'h0602, 0, 1, S_FAT, 1, 19, 0, "R5");
        cor_mask = cor_mask | (32'h1 << 13);
        send(32'h1 << 21, 0, 1, 16'h0603, 0, 0, S_COR, 0, 0, 0, "R5");
        cor_mask = 32'h1 << 7;

        // R8 log overflow follow-on
        exp_unc |= 32'h1 << 22; exp_cor |= 32'h1 << 15;
        send(32'h1 << 22, 0, 0, 16'h0A31, 1, 1, S_NF, 0, 0, 1, "R8");

        summary();
        $finish;
    end

endmodule